// File: doc/BRIEF.md
# Periodic Battery Health Monitor

This block decides when a backup battery is put under test and what the result means. While main power is good, it waits out a recovery delay after each power-up. It then runs a test window. During the window it raises a load-enable output that switches an external test load onto the battery. It also watches a digital flag from an external comparator that reports the battery sagging below its trip point. After a passing test it counts out a long interval and tests again, and this repeats for as long as power stays good.

A failed test latches a warning, which is presented as the pull-down enable of an open-drain line. Once the warning is set, periodic testing stops. The next power-up forces a retest anyway. A passing retest releases the warning and starts the periodic schedule again from zero. When main power fails, all timing is suspended, the load is released in the same cycle, and a test that was cut short leaves the warning as it was. All time bases are parameters in clock ticks. This lets a real one-day interval and a one-second window be scaled down for simulation.

Top module: `batt_health_mon`

## Requirements
- R1: While rst_ni is low and directly after reset, load_en_o is 0 and warn_od_o is 0. warn_od_o = 1 means the open-drain warning line is pulled low (warning active); 0 means released.
- R2: After the first clock edge that samples pwr_good_i high following a power-bad period, RECOVERY_TICKS cycles pass with load_en_o low, and then the test window starts.
- R3: A test window lasts exactly WINDOW_TICKS consecutive cycles with load_en_o high, provided power stays good.
- R4: After a passing window, load_en_o stays low for exactly INTERVAL_TICKS cycles, and then the next window starts.
- R5: If batt_low_i is high in any cycle of a complete window, warn_od_o becomes 1 in the cycle after the last window cycle. If it is high in no cycle of the window, warn_od_o becomes 0.
- R6: While the warning is set and power stays good, no further window is started (load_en_o stays 0).
- R7: Every power-up runs a test even when warn_od_o is 1. A passing test clears warn_od_o and resumes the periodic schedule.
- R8: When pwr_good_i is low, load_en_o is 0 in that same cycle and all timers are stopped and cleared.
- R9: A window cut short by power loss does not change warn_od_o, even if batt_low_i was seen during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_good_i | input | 1 | Main supply within tolerance |
| batt_low_i | input | 1 | Comparator flag: battery below trip point |
| load_en_o | output | 1 | Connects the test load to the battery |
| warn_od_o | output | 1 | Pull-down enable of the open-drain warning line |

## Verification
The bench builds the block with RECOVERY_TICKS=5, WINDOW_TICKS=6 and INTERVAL_TICKS=40. With these values a full power-up, test and interval cycle takes about fifty clocks, so many rounds of the schedule fit into one run. The same short timers let power drops land at every phase: during recovery, inside a window (including its last cycle) and during the interval. They also let latched warnings be cleared and re-set several times across random power cycling.

// File: rtl/bhm_pkg.sv
package bhm_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_RECOV = 3'd1,
    ST_TEST  = 3'd2,
    ST_WAIT  = 3'd3,
    ST_HOLD  = 3'd4
  } bhm_state_e;
endpackage

// File: rtl/bhm_timer.sv
module bhm_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end

  // R3: a running count never passes its terminal value
  a_r3_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && $stable(limit_i) |=> cnt_q <= limit_i);
endmodule

// File: rtl/bhm_verdict.sv
module bhm_verdict (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic sample_i,
  input  logic low_i,
  input  logic commit_i,
  output logic fail_o,
  output logic warn_o
);
  logic acc_q;

  assign fail_o = acc_q | (sample_i & low_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= 1'b0;
    else if (start_i)  acc_q <= 1'b0;
    else if (sample_i) acc_q <= fail_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       warn_o <= 1'b0;
    else if (commit_i) warn_o <= fail_o;
  end

  // R9: without a commit the warning holds
  a_r9_warn_only_on_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(warn_o));
endmodule

// File: rtl/batt_health_mon.sv
module batt_health_mon
  import bhm_pkg::*;
#(
  parameter int RECOVERY_TICKS = 200,
  parameter int WINDOW_TICKS   = 1000,
  parameter int INTERVAL_TICKS = 86_400_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic batt_low_i,
  output logic load_en_o,
  output logic warn_od_o
);
  localparam int MAX_A = (RECOVERY_TICKS > WINDOW_TICKS) ? RECOVERY_TICKS : WINDOW_TICKS;
  localparam int MAX_T = (MAX_A > INTERVAL_TICKS) ? MAX_A : INTERVAL_TICKS;
  localparam int CNT_W = $clog2(MAX_T + 1);
  localparam logic [CNT_W-1:0] LIM_REC = CNT_W'(RECOVERY_TICKS - 1);
  localparam logic [CNT_W-1:0] LIM_WIN = CNT_W'(WINDOW_TICKS - 1);
  localparam logic [CNT_W-1:0] LIM_INT = CNT_W'(INTERVAL_TICKS - 1);

  bhm_state_e       state_q, state_d;
  logic [CNT_W-1:0] limit;
  logic             done, fail, in_test, start, commit, clr;

  assign in_test = (state_q == ST_TEST) && pwr_good_i;
  assign commit  = in_test && done;
  assign start   = (state_d == ST_TEST) && (state_q != ST_TEST);
  assign clr     = (state_d != state_q) || !pwr_good_i;

  always_comb begin
    case (state_q)
      ST_RECOV: limit = LIM_REC;
      ST_TEST:  limit = LIM_WIN;
      ST_WAIT:  limit = LIM_INT;
      default:  limit = '0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    if (!pwr_good_i) state_d = ST_OFF;
    else begin
      case (state_q)
        ST_OFF:   state_d = ST_RECOV;
        ST_RECOV: if (done) state_d = ST_TEST;
        ST_TEST:  if (done) state_d = fail ? ST_HOLD : ST_WAIT;
        ST_WAIT:  if (done) state_d = ST_TEST;
        ST_HOLD:  state_d = ST_HOLD;
        default:  state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  bhm_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .limit_i (limit),
    .done_o  (done)
  );

  bhm_verdict u_verdict (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .sample_i (in_test),
    .low_i    (batt_low_i),
    .commit_i (commit),
    .fail_o   (fail),
    .warn_o   (warn_od_o)
  );

  // load released in the same cycle as a power loss
  assign load_en_o = in_test;

  a_r5_warn_set_after_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(warn_od_o) |-> $past(load_en_o));
  a_r7_warn_clear_after_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(warn_od_o) |-> $past(load_en_o));
  a_r8_pwr_loss_holds_warn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> $stable(warn_od_o));
  a_r6_hold_keeps_load_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD) |-> !load_en_o);
endmodule

// File: tb/batt_health_mon_tb_top.sv
module batt_health_mon_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int REC = 5;
  localparam int WIN = 6;
  localparam int INTV = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr = 1'b0;
  logic low = 1'b0;
  logic load_en, warn;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference model: 0 off, 1 recovery, 2 window, 3 interval, 4 hold
  int m_state = 0;
  int m_cnt = 0;
  bit m_acc = 1'b0;
  bit m_warn = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  batt_health_mon #(
    .RECOVERY_TICKS (REC),
    .WINDOW_TICKS   (WIN),
    .INTERVAL_TICKS (INTV)
  ) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pwr_good_i (pwr),
    .batt_low_i (low),
    .load_en_o  (load_en),
    .warn_od_o  (warn)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state <= 0; m_cnt <= 0; m_acc <= 1'b0; m_warn <= 1'b0;
    end else if (!pwr) begin
      m_state <= 0; m_cnt <= 0;
    end else begin
      case (m_state)
        0: begin m_state <= 1; m_cnt <= 0; end
        1: if (m_cnt == REC-1) begin m_state <= 2; m_cnt <= 0; m_acc <= 1'b0; end
           else m_cnt <= m_cnt + 1;
        2: if (m_cnt == WIN-1) begin
             m_warn  <= m_acc | low;
             m_state <= (m_acc | low) ? 4 : 3;
             m_cnt   <= 0;
           end else begin
             m_acc <= m_acc | low;
             m_cnt <= m_cnt + 1;
           end
        3: if (m_cnt == INTV-1) begin m_state <= 2; m_cnt <= 0; m_acc <= 1'b0; end
           else m_cnt <= m_cnt + 1;
        default: m_state <= 4;
      endcase
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic string load_tag(input int st, input logic p);
    if (!p)       return "R8";
    if (st == 1)  return "R2";
    if (st == 2)  return "R3";
    if (st == 3)  return "R4";
    if (st == 4)  return "R6";
    return "R2";
  endfunction

  task automatic step(input logic p, input logic l);
    @(negedge clk);
    pwr = p; low = l;
    #1;
    check(load_tag(m_state, p), load_en, (m_state == 2) && p);
    check("R5", warn, m_warn);
  endtask

  task automatic run_until_window();
    int guard = 0;
    while (m_state != 2 && guard < 500) begin step(1'b1, 1'b0); guard++; end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1", load_en, 1'b0);
    check("R1", warn, 1'b0);
    rst_n = 1'b1;
    step(1'b0, 1'b0);
    check("R1", warn, 1'b0);

    // R2/R3/R4: two passing rounds
    repeat (REC + 2*WIN + INTV + 8) step(1'b1, 1'b0);

    // R5: one low sample mid-window latches the warning
    run_until_window();
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    repeat (WIN) step(1'b1, 1'b0);
    check("R5", warn, 1'b1);

    // R6: no periodic window while warning is set
    for (int i = 0; i < 2*INTV; i++) begin
      step(1'b1, 1'b0);
      check("R6", load_en, 1'b0);
    end

    // R7: power cycle with healthy battery clears warning
    repeat (4) step(1'b0, 1'b0);
    repeat (REC + WIN + 3) step(1'b1, 1'b0);
    check("R7", warn, 1'b0);

    // R8/R9: low seen, then power lost inside window
    run_until_window();
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    check("R8", load_en, 1'b0);
    repeat (3) step(1'b0, 1'b0);
    repeat (REC + 2) step(1'b1, 1'b0);
    check("R9", warn, 1'b0);

    // R7: retest also fails when battery stays low, warning set, then cleared
    run_until_window();
    repeat (WIN + 1) step(1'b1, 1'b1);
    check("R5", warn, 1'b1);
    repeat (2) step(1'b0, 1'b0);
    run_until_window();
    repeat (WIN + 1) step(1'b1, 1'b0);
    check("R7", warn, 1'b0);
    repeat (INTV + 2) step(1'b1, 1'b0);
    check("R4", load_en, 1'b1);

    // random power cycling and comparator noise
    for (int i = 0; i < 6000; i++) begin
      logic p, l;
      p = ($urandom % 100) != 0;
      l = ($urandom % 25) == 0;
      step(p, l);
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule